// File: doc/BRIEF.md
# QPSK Subcarrier Mapper with Transform Start

This block turns a serial bit stream into one frequency-domain OFDM symbol at a time, ready for an inverse transform. Each pair of consecutive accepted bits becomes one QPSK point, and the points are written into a 512-entry buffer of 2-bit codes. When a symbol is requested, the block emits 512 complex samples, one per clock and in natural transform order. Bin 0 (DC) is zero. Bins 1 to 150 and bins 362 to 511 take buffered points in order. Every other bin is zero.

A one-cycle transform start pulse precedes the first sample of every symbol by three clock cycles. The bit input is back-pressured, so at most one symbol's worth of points, 300 points or 600 bits, is held at a time. If fewer than 300 points are buffered when a symbol begins, the block flags underflow for that symbol. Data bins that find the buffer empty are then driven with zero.

Top module: `qpsk_bin_mapper`

## Requirements
- R1: Bits are paired in arrival order. The first bit of a pair sets the sign of I and the second sets the sign of Q, with 0 giving +AMP and 1 giving -AMP (AMP defaults to 5793). So 00 gives (+,+), 01 gives (+,-), 10 gives (-,+) and 11 gives (-,-).
- R2: Within a symbol, bin 0 and bins 151 to 361 are (0,0). Bins 1 to 150 and then bins 362 to 511 carry the buffered points, oldest first.
- R3: `fftStart` is high for exactly one cycle, three cycles before the sample of bin 0 appears.
- R4: `outValid` is high for 512 consecutive cycles per symbol, with bins in ascending order from 0 to 511. Outside a symbol, `outValid` is low.
- R5: `bitReady` is high exactly when fewer than 300 points are buffered. A bit is taken on every cycle where `bitValid` and `bitReady` are both high.
- R6: If fewer than 300 points are buffered when a symbol begins, `outUnderflow` is high for all 512 samples of that symbol and data bins beyond the buffered points are (0,0). Otherwise `outUnderflow` is low.
- R7: `symReq` is acted on only while idle or during the cycle of the last bin. A request at any other time is ignored and produces no extra `fftStart` and no extra symbol.
- R8: A request held during the last bin starts the next symbol at once. Its `fftStart` falls in the same cycle as the sample of bin 511 of the previous symbol.
- R9: After reset, `outValid`, `fftStart` and `outUnderflow` are low, the outputs are zero, the buffer is empty and `bitReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitIn | input | 1 | Serial data bit |
| bitValid | input | 1 | `bitIn` is valid |
| bitReady | output | 1 | The block can accept a bit |
| symReq | input | 1 | Request to emit one symbol |
| outI | output | SAMPLE_W | Signed in-phase sample |
| outQ | output | SAMPLE_W | Signed quadrature sample |
| outValid | output | 1 | Sample valid, one bin per cycle |
| outUnderflow | output | 1 | The current symbol started short of data |
| fftStart | output | 1 | Transform start pulse |

## Verification
The assertions assume that `bitValid` and `bitIn` change only between clock edges. They also assume that `symReq` is a level the block samples, not a handshake. Stimulus is driven on the falling edge. A bench model of the point queue, fed only by accepted bits, predicts every sample and the underflow flag. Random valid density fills the buffer for full symbols. Fixed bit budgets, with feeding switched off, give known partial and empty buffers for the underflow and back-to-back cases.

// File: rtl/qmap_pkg.sv
package qmap_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LEAD = 2'd1,
    PH_RUN  = 2'd2
  } phase_t;

  // Strobes from control to datapath, valid in the cycle a bin is processed
  typedef struct packed {
    logic binActive;  // a bin of a symbol is being produced
    logic dataBin;    // this bin belongs to a data group
    logic underflow;  // current symbol started short of points
  } ctrlStrobes_t;

endpackage

// File: rtl/qmap_ctrl.sv
module qmap_ctrl
  import qmap_pkg::*;
#(
  parameter int NFFT       = 512,
  parameter int GRP        = 150,
  parameter int START_LEAD = 3,
  parameter int LEVEL_W    = 9
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               symReq,
  input  logic [LEVEL_W-1:0] level,
  output ctrlStrobes_t       strb,
  output logic               fftStart
);

  localparam int BIN_W    = $clog2(NFFT);
  localparam int DATA_PTS = 2 * GRP;
  localparam int LEAD_CYC = START_LEAD - 1;
  localparam int LEAD_W   = (LEAD_CYC > 1) ? $clog2(LEAD_CYC) : 1;
  localparam logic [BIN_W-1:0]   LAST_BIN  = BIN_W'(NFFT - 1);
  localparam logic [BIN_W-1:0]   UPPER_END = BIN_W'(GRP);
  localparam logic [BIN_W-1:0]   LOWER_BEG = BIN_W'(NFFT - GRP);
  localparam logic [LEAD_W-1:0]  LEAD_END  = LEAD_W'(LEAD_CYC - 1);
  localparam logic [LEVEL_W-1:0] FULL_LVL  = LEVEL_W'(DATA_PTS);

  phase_t            phase;
  logic [BIN_W-1:0]  binIdx;
  logic [LEAD_W-1:0] leadCnt;
  logic              symUnder;
  logic              lastBin;
  logic              inData;

  assign lastBin = (phase == PH_RUN) && (binIdx == LAST_BIN);
  assign inData  = ((binIdx != '0) && (binIdx <= UPPER_END)) || (binIdx >= LOWER_BEG);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      binIdx   <= '0;
      leadCnt  <= '0;
      symUnder <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (symReq) begin
            phase   <= PH_LEAD;
            leadCnt <= '0;
          end
        end
        PH_LEAD: begin
          if (leadCnt == LEAD_END) begin
            phase    <= PH_RUN;
            binIdx   <= '0;
            symUnder <= (level < FULL_LVL);
          end else begin
            leadCnt <= leadCnt + 1'b1;
          end
        end
        PH_RUN: begin
          if (binIdx == LAST_BIN) begin
            phase   <= symReq ? PH_LEAD : PH_IDLE;
            leadCnt <= '0;
          end else begin
            binIdx <= binIdx + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign fftStart       = (phase == PH_LEAD) && (leadCnt == '0);
  assign strb.binActive = (phase == PH_RUN);
  assign strb.dataBin   = (phase == PH_RUN) && inData;
  assign strb.underflow = symUnder;

  // R3: the start pulse lasts one cycle
  a_r3_start_single: assert property (@(posedge clk) disable iff (!rstN)
    fftStart |=> !fftStart);

  // R4: bins advance by one without gaps inside a symbol
  a_r4_bin_step: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_RUN && !lastBin) |=> (phase == PH_RUN && binIdx == $past(binIdx) + 1'b1));

  // R7: no start pulse while a symbol is mid-way
  a_r7_no_mid_start: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_RUN && !lastBin) |=> !fftStart);

endmodule

// File: rtl/qmap_datapath.sv
module qmap_datapath
  import qmap_pkg::*;
#(
  parameter int DEPTH    = 300,
  parameter int SAMPLE_W = 16,
  parameter int AMP      = 5793,
  parameter int LEVEL_W  = 9
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       bitIn,
  input  logic                       bitValid,
  output logic                       bitReady,
  input  ctrlStrobes_t               strb,
  output logic [LEVEL_W-1:0]         level,
  output logic signed [SAMPLE_W-1:0] outI,
  output logic signed [SAMPLE_W-1:0] outQ,
  output logic                       outValid,
  output logic                       outUnderflow
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0]   PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [LEVEL_W-1:0] DEPTH_L  = LEVEL_W'(DEPTH);
  localparam logic signed [SAMPLE_W-1:0] POS_A = SAMPLE_W'(AMP);
  localparam logic signed [SAMPLE_W-1:0] NEG_A = SAMPLE_W'(-AMP);

  logic [1:0]       mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic             haveFirst, firstBit;
  logic             accept, push, pop;
  logic [1:0]       rdCode;

  assign bitReady = (level < DEPTH_L);
  assign accept   = bitValid && bitReady;
  assign push     = accept && haveFirst;
  assign pop      = strb.dataBin && (level != '0);
  assign rdCode   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= {firstBit, bitIn};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      haveFirst <= 1'b0;
      firstBit  <= 1'b0;
      wrPtr     <= '0;
      rdPtr     <= '0;
      level     <= '0;
    end else begin
      if (accept) begin
        haveFirst <= !haveFirst;
        if (!haveFirst) firstBit <= bitIn;
      end
      if (push) wrPtr <= (wrPtr == PTR_LAST) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == PTR_LAST) ? '0 : rdPtr + 1'b1;
      unique case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outI         <= '0;
      outQ         <= '0;
      outValid     <= 1'b0;
      outUnderflow <= 1'b0;
    end else begin
      outValid     <= strb.binActive;
      outUnderflow <= strb.binActive && strb.underflow;
      if (pop) begin
        outI <= rdCode[1] ? NEG_A : POS_A;
        outQ <= rdCode[0] ? NEG_A : POS_A;
      end else begin
        outI <= '0;
        outQ <= '0;
      end
    end
  end

  // R5: the buffer never holds more than one symbol of points
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    level <= DEPTH_L);

  // R2: a non-data bin comes out as zero
  a_r2_null_bin: assert property (@(posedge clk) disable iff (!rstN)
    (strb.binActive && !strb.dataBin) |=> (outValid && outI == '0 && outQ == '0));

  // R6: an empty buffer yields a zero data bin
  a_r6_empty_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strb.dataBin && level == '0) |=> (outI == '0 && outQ == '0));

  // R1: a nonzero sample always has the constellation magnitude
  a_r1_amplitude: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outI != '0) |-> ((outI == POS_A || outI == NEG_A) &&
                                  (outQ == POS_A || outQ == NEG_A)));

endmodule

// File: rtl/qpsk_bin_mapper.sv
module qpsk_bin_mapper
  import qmap_pkg::*;
#(
  parameter int NFFT       = 512,
  parameter int GRP        = 150,
  parameter int START_LEAD = 3,
  parameter int SAMPLE_W   = 16,
  parameter int AMP        = 5793
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       bitIn,
  input  logic                       bitValid,
  output logic                       bitReady,
  input  logic                       symReq,
  output logic signed [SAMPLE_W-1:0] outI,
  output logic signed [SAMPLE_W-1:0] outQ,
  output logic                       outValid,
  output logic                       outUnderflow,
  output logic                       fftStart
);

  localparam int DATA_PTS = 2 * GRP;
  localparam int LEVEL_W  = $clog2(DATA_PTS + 1);

  ctrlStrobes_t       strb;
  logic [LEVEL_W-1:0] level;

  qmap_ctrl #(
    .NFFT(NFFT), .GRP(GRP), .START_LEAD(START_LEAD), .LEVEL_W(LEVEL_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .symReq(symReq), .level(level),
    .strb(strb), .fftStart(fftStart)
  );

  qmap_datapath #(
    .DEPTH(DATA_PTS), .SAMPLE_W(SAMPLE_W), .AMP(AMP), .LEVEL_W(LEVEL_W)
  ) uData (
    .clk(clk), .rstN(rstN), .bitIn(bitIn), .bitValid(bitValid),
    .bitReady(bitReady), .strb(strb), .level(level),
    .outI(outI), .outQ(outQ), .outValid(outValid), .outUnderflow(outUnderflow)
  );

endmodule

// File: tb/tb_qpsk_bin_mapper.sv
module tb_qpsk_bin_mapper;

  localparam int NFFT = 512;
  localparam int GRP  = 150;
  localparam int PTS  = 2 * GRP;
  localparam int SW   = 16;
  localparam int AMP  = 5793;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitIn = 1'b0, bitValid = 1'b0, symReq = 1'b0;
  logic bitReady, outValid, outUnderflow, fftStart;
  logic signed [SW-1:0] outI, outQ;

  qpsk_bin_mapper #(.NFFT(NFFT), .GRP(GRP), .START_LEAD(3), .SAMPLE_W(SW), .AMP(AMP)) dut (
    .clk(clk), .rstN(rstN), .bitIn(bitIn), .bitValid(bitValid), .bitReady(bitReady),
    .symReq(symReq), .outI(outI), .outQ(outQ), .outValid(outValid),
    .outUnderflow(outUnderflow), .fftStart(fftStart)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  logic [1:0] q [$];
  int  budget = 0, density = 50;
  logic haveFirst = 1'b0, firstBit = 1'b0;
  int  cyc = 0, lastStart = -100, startCount = 0, symDone = 0, bIdx = 0;
  logic monOn = 1'b0, expUnder = 1'b0, sawStartOnLast = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic signed [SW-1:0] lvl(input logic b);
    return b ? SW'(-AMP) : SW'(AMP);
  endfunction

  function automatic bit isData(input int b);
    return (b >= 1 && b <= GRP) || (b >= NFFT - GRP);
  endfunction

  task automatic finishUp();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // bit driver: negedge drive, acceptance judged before the next posedge
  initial begin
    forever begin
      @(negedge clk);
      bitValid = (budget > 0) && ($urandom_range(0, 99) < density);
      bitIn    = $urandom_range(0, 1);
      #1;
      if (monOn) check(bitReady == (q.size() < PTS), "R5", "bitReady", bitReady, q.size() < PTS);
      if (bitValid && bitReady) begin
        budget--;
        if (haveFirst) q.push_back({firstBit, bitIn});
        else firstBit = bitIn;
        haveFirst = !haveFirst;
      end
    end
  end

  // output monitor
  initial begin
    forever begin
      @(negedge clk);
      if (monOn) begin
        cyc++;
        if (fftStart) begin
          startCount++;
          lastStart = cyc;
          if (outValid && bIdx == NFFT - 1) sawStartOnLast = 1'b1;
        end
        if (outValid) begin
          logic signed [SW-1:0] eI, eQ;
          if (bIdx == 0) begin
            check(cyc == lastStart + 3, "R3", "bin0 offset from start", cyc - lastStart, 3);
            expUnder = (q.size() < PTS);
          end
          check(outUnderflow == expUnder, "R6", "underflow flag", outUnderflow, expUnder);
          eI = '0; eQ = '0;
          if (isData(bIdx) && q.size() > 0) begin
            logic [1:0] c;
            c = q.pop_front();
            eI = lvl(c[1]); eQ = lvl(c[0]);
          end
          check(outI == eI, "R1/R2", $sformatf("I bin %0d", bIdx), outI, eI);
          check(outQ == eQ, "R1/R2", $sformatf("Q bin %0d", bIdx), outQ, eQ);
          bIdx = (bIdx + 1) % NFFT;
          if (bIdx == 0) symDone++;
        end else begin
          check(bIdx == 0, "R4", "valid gap inside symbol", bIdx, 0);
          check(outUnderflow == 1'b0, "R6", "underflow while idle", outUnderflow, 0);
        end
      end
    end
  end

  task automatic waitFull();
    budget = 1_000_000;
    do @(negedge clk); while (bitReady);
    budget = 0;
  endtask

  task automatic requestOne();
    @(negedge clk); symReq = 1'b1;
    @(negedge clk); symReq = 1'b0;
  endtask

  task automatic waitSym(input int n);
    while (symDone < n) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    // R9: reset state
    check(outValid == 0 && fftStart == 0 && outUnderflow == 0, "R9", "flags in reset",
          {outValid, fftStart, outUnderflow}, 0);
    check(outI == 0 && outQ == 0, "R9", "samples in reset", outI, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(bitReady == 1'b1, "R9", "bitReady after reset", bitReady, 1);
    monOn = 1'b1;

    // full symbols with random feeding density
    for (int s = 0; s < 3; s++) begin
      density = 20 + 30 * s;
      waitFull();
      budget = 1_000_000;
      requestOne();
      if (s == 1) begin
        // R7: a request mid-symbol is ignored
        repeat (200) @(negedge clk);
        symReq = 1'b1; @(negedge clk); symReq = 1'b0;
      end
      waitSym(s + 1);
      budget = 0;
      repeat (10) @(negedge clk);
      check(startCount == s + 1, "R7", "start pulses", startCount, s + 1);
      check(outValid == 1'b0, "R7", "no extra symbol", outValid, 0);
    end

    // R6: drain leftovers with feeding off (partial underflow)
    requestOne();
    waitSym(4);
    check(q.size() == 0, "R6", "queue drained", q.size(), 0);

    // R6: exactly 37 points buffered
    density = 100;
    budget = 74;
    while (budget > 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check(q.size() == 37, "R5", "points buffered", q.size(), 37);
    requestOne();
    waitSym(5);

    // R8: back-to-back symbols from a held request; second runs empty
    density = 70;
    waitFull();
    @(negedge clk); symReq = 1'b1;
    while (startCount < 7) @(negedge clk);
    symReq = 1'b0;
    waitSym(7);
    check(sawStartOnLast == 1'b1, "R8", "start on last bin", sawStartOnLast, 1);
    check(startCount == 7, "R8", "start count", startCount, 7);

    finishUp();
  end

  initial begin
    #(200_000 * 8);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", symDone, 7);
    finishUp();
  end

endmodule